// File: doc/BRIEF.md
# DMA Channel Interrupt Controller

This block holds the interrupt state of every channel of a DMA controller. For each channel the transfer engine delivers single-cycle event pulses for five sources: fragment done, block done, transaction done, linked-list done and configuration error. Each pulse is captured in a sticky status bit. A per-channel enable mask gates the status bits onto that channel's interrupt line. Software clears status by writing ones to a clear field in the same channel register.

Two global words summarise all channels. The raw word has bit i set while channel i holds any status bit, enabled or not. The masked word has bit i set while channel i drives its interrupt. Each channel also keeps a two-bit request mode. From it the block derives a one-cycle completion pulse. The pulse fires when an incoming event belongs to a level at least as deep as the programmed mode.

Register access uses a simple write strobe with a combinational read port. The raw word is at offset 0x10, the masked word at 0x14, and the register of channel i at 0x40 + 4*i.

Top module: `dma_chan_intc`

## Requirements
- R1: After reset every enable, status and mode field is 0, every interrupt line, global bit and completion pulse is low, and every channel register reads 0.
- R2: An event pulse on source k of a channel (bit k of that channel's five-bit slice of `evt_pulse`; k = 0 fragment, 1 block, 2 transaction, 3 list, 4 configuration error) sets status bit k at the next clock edge, whether or not enable bit k is set.
- R3: `ch_irq[i]` is high exactly while some status bit of channel i is set together with its enable bit; a write that changes enables takes effect at the next edge.
- R4: A write to a channel register with a 1 in bit 24+k clears status bit k at that edge; a 0 there leaves the bit unchanged.
- R5: When a clear and an event hit the same status bit in the same cycle, the bit ends up set.
- R6: Global raw word (offset 0x10, also on `glb_raw`) bit i is the OR of channel i's status bits; global masked word (offset 0x14, also on `glb_masked`) bit i equals `ch_irq[i]`.
- R7: Channel register i at offset 0x40 + 4*i reads enables in [4:0], mode in [9:8], status in [20:16] and 0 elsewhere; a write loads enables from [4:0] and mode from [9:8].
- R8: `xfer_done[i]` is high for exactly the one cycle after an edge where channel i received an event of level L (fragment 1, block 2, transaction 3, list 4) with L >= mode+1, using the mode held before that edge; configuration-error events never count.
- R9: Writes to offsets other than a channel register (including 0x10, 0x14 and unmapped ones) change no state; reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for write and read |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| evt_pulse | input | NUM_CH*5 | Event pulses, channel i at bits [5i+4:5i] |
| ch_irq | output | NUM_CH | Per-channel interrupt lines |
| glb_raw | output | NUM_CH | Any status pending per channel |
| glb_masked | output | NUM_CH | Enabled status pending per channel |
| xfer_done | output | NUM_CH | Completion pulse per channel |

## Verification
Status, enables, mode, interrupt lines and both global words change at the edge that samples an event or write. The completion pulse is registered at that same edge and lasts one cycle. Read data follows `reg_addr` with no clock delay. The bench drives inputs in the low phase and steps one edge. It updates its model right after that edge and compares every output at the following falling edge. It then sweeps `reg_addr` over all channel registers and both global words in sub-nanosecond steps before the next edge.

// File: rtl/dma_intc_pkg.sv
`timescale 1ns/1ps
package dma_intc_pkg;
    localparam int NSRC     = 5;   // fragment, block, transaction, list, cfg error
    localparam int NLVL     = 4;   // sources that count as completion levels
    localparam int MODE_W   = 2;
    localparam int EN_LSB   = 0;
    localparam int MODE_LSB = 8;
    localparam int STS_LSB  = 16;
    localparam int CLR_LSB  = 24;
    localparam int RAW_OFS  = 'h10;
    localparam int MSK_OFS  = 'h14;
    localparam int CH_BASE  = 'h40;
    localparam int CH_STEP  = 4;

    typedef struct packed {
        logic [NSRC-1:0]   en;
        logic [MODE_W-1:0] mode;
        logic [NSRC-1:0]   sts;
        logic              done;
    } chan_state_t;

    function automatic int ch_ofs(input int idx);
        return CH_BASE + CH_STEP * idx;
    endfunction
endpackage

// File: rtl/dma_intc_wr_dec.sv
`timescale 1ns/1ps
module dma_intc_wr_dec
    import dma_intc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] ch_wr
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        localparam logic [ADDR_W-1:0] CH_A = ADDR_W'(ch_ofs(i));
        assign ch_wr[i] = we && (addr == CH_A);
    end
endmodule

// File: rtl/dma_intc_chan.sv
`timescale 1ns/1ps
module dma_intc_chan
    import dma_intc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   evt,
    output logic [NSRC-1:0]   en_o,
    output logic [NSRC-1:0]   sts_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              irq_o,
    output logic              done_o
);
    chan_state_t     st_d, st_q;
    logic [NSRC-1:0] clr_mask;
    logic            lvl_hit;

    always_comb begin
        st_d     = st_q;
        clr_mask = '0;
        lvl_hit  = 1'b0;
        // completion judged against the mode held before this edge
        for (int k = 0; k < NLVL; k++) begin
            if (evt[k] && (k >= int'(st_q.mode))) begin
                lvl_hit = 1'b1;
            end
        end
        if (wr_sel) begin
            st_d.en   = wdata[EN_LSB +: NSRC];
            st_d.mode = wdata[MODE_LSB +: MODE_W];
            clr_mask  = wdata[CLR_LSB +: NSRC];
        end
        // set has priority over a same-cycle clear
        st_d.sts  = (st_q.sts & ~clr_mask) | evt;
        st_d.done = lvl_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign sts_o  = st_q.sts;
    assign mode_o = st_q.mode;
    assign irq_o  = |(st_q.sts & st_q.en);
    assign done_o = st_q.done;
endmodule

// File: rtl/dma_intc_rd_mux.sv
`timescale 1ns/1ps
module dma_intc_rd_mux
    import dma_intc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [NUM_CH-1:0][NSRC-1:0]        en,
    input  logic [NUM_CH-1:0][NSRC-1:0]        sts,
    input  logic [NUM_CH-1:0][MODE_W-1:0]      mode,
    input  logic [NUM_CH-1:0]                  raw,
    input  logic [NUM_CH-1:0]                  masked,
    output logic [DATA_W-1:0]                  rdata
);
    localparam logic [ADDR_W-1:0] RAW_A = ADDR_W'(RAW_OFS);
    localparam logic [ADDR_W-1:0] MSK_A = ADDR_W'(MSK_OFS);

    always_comb begin
        rdata = '0;
        if (addr == RAW_A) begin
            rdata[NUM_CH-1:0] = raw;
        end
        if (addr == MSK_A) begin
            rdata[NUM_CH-1:0] = masked;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(ch_ofs(i))) begin
                rdata[EN_LSB +: NSRC]     = en[i];
                rdata[MODE_LSB +: MODE_W] = mode[i];
                rdata[STS_LSB +: NSRC]    = sts[i];
            end
        end
    end
endmodule

// File: rtl/dma_chan_intc.sv
`timescale 1ns/1ps
module dma_chan_intc
    import dma_intc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    input  logic [NUM_CH*NSRC-1:0] evt_pulse,
    output logic [NUM_CH-1:0]      ch_irq,
    output logic [NUM_CH-1:0]      glb_raw,
    output logic [NUM_CH-1:0]      glb_masked,
    output logic [NUM_CH-1:0]      xfer_done
);
    logic [NUM_CH-1:0]             ch_wr;
    logic [NUM_CH-1:0][NSRC-1:0]   en_arr;
    logic [NUM_CH-1:0][NSRC-1:0]   sts_arr;
    logic [NUM_CH-1:0][MODE_W-1:0] mode_arr;

    dma_intc_wr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .we    (reg_we),
        .addr  (reg_addr),
        .ch_wr (ch_wr)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dma_intc_chan #(.DATA_W(DATA_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_sel (ch_wr[i]),
            .wdata  (reg_wdata),
            .evt    (evt_pulse[i*NSRC +: NSRC]),
            .en_o   (en_arr[i]),
            .sts_o  (sts_arr[i]),
            .mode_o (mode_arr[i]),
            .irq_o  (ch_irq[i]),
            .done_o (xfer_done[i])
        );
        assign glb_raw[i] = |sts_arr[i];
    end

    assign glb_masked = ch_irq;

    dma_intc_rd_mux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .addr   (reg_addr),
        .en     (en_arr),
        .sts    (sts_arr),
        .mode   (mode_arr),
        .raw    (glb_raw),
        .masked (glb_masked),
        .rdata  (reg_rdata)
    );
endmodule

// File: rtl/dma_intc_chk.sv
`timescale 1ns/1ps
module dma_intc_chk
    import dma_intc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   reg_we,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic [DATA_W-1:0]      reg_wdata,
    input logic [NUM_CH*NSRC-1:0] evt_pulse,
    input logic [NUM_CH-1:0]      ch_irq,
    input logic [NUM_CH-1:0]      glb_raw,
    input logic [NUM_CH-1:0]      glb_masked,
    input logic [NUM_CH-1:0]      xfer_done,
    input logic [NUM_CH-1:0][NSRC-1:0] en_arr,
    input logic [NUM_CH-1:0][NSRC-1:0] sts_arr
);
    // R6: a channel cannot be masked-pending without being raw-pending
    a_r6_masked_within_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_masked & ~glb_raw) == '0)
        else $error("masked status outside raw status");

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] CH_A = ADDR_W'(ch_ofs(i));
        logic wr_hit;
        assign wr_hit = reg_we && (reg_addr == CH_A);

        // R3: no interrupt while all enables are clear
        a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
            (en_arr[i] == '0) |-> !ch_irq[i])
            else $error("interrupt with all enables clear");

        // R8: completion pulse needs a level event one edge earlier
        a_r8_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
            xfer_done[i] |-> $past(|evt_pulse[i*NSRC +: NLVL]))
            else $error("completion pulse without level event");

        for (genvar k = 0; k < NSRC; k++) begin : g_src
            // R2: event latches status
            a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
                evt_pulse[i*NSRC+k] |=> sts_arr[i][k])
                else $error("event did not latch");
            // R4: clear without event empties the bit
            a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_hit && reg_wdata[CLR_LSB+k] && !evt_pulse[i*NSRC+k]) |=> !sts_arr[i][k])
                else $error("clear did not take");
            // R5: set wins over clear
            a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_hit && reg_wdata[CLR_LSB+k] && evt_pulse[i*NSRC+k]) |=> sts_arr[i][k])
                else $error("clear beat a same-cycle event");
        end
    end
endmodule

bind dma_chan_intc dma_intc_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .evt_pulse  (evt_pulse),
    .ch_irq     (ch_irq),
    .glb_raw    (glb_raw),
    .glb_masked (glb_masked),
    .xfer_done  (xfer_done),
    .en_arr     (en_arr),
    .sts_arr    (sts_arr)
);

// File: tb/dma_chan_intc_tb.sv
`timescale 1ns/1ps
module dma_chan_intc_tb;
    localparam int NCH = 4;
    localparam int NS  = 5;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            reg_we;
    logic [7:0]      reg_addr;
    logic [31:0]     reg_wdata;
    logic [31:0]     reg_rdata;
    logic [NCH*NS-1:0] evt_pulse;
    logic [NCH-1:0]  ch_irq, glb_raw, glb_masked, xfer_done;

    always #4 clk = ~clk;   // 125 MHz

    dma_chan_intc #(.NUM_CH(NCH), .ADDR_W(8), .DATA_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
        .ch_irq(ch_irq), .glb_raw(glb_raw), .glb_masked(glb_masked),
        .xfer_done(xfer_done)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [4:0] m_en   [NCH];
    logic [1:0] m_mode [NCH];
    logic [4:0] m_sts  [NCH];
    logic       m_done [NCH];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] ch_a(input int ch);
        return 8'(64 + 4 * ch);
    endfunction

    function automatic logic [NCH*NS-1:0] ev(input int ch, input int k);
        logic [NCH*NS-1:0] v = '0;
        v[ch*NS + k] = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] exp_reg(input int ch);
        logic [31:0] r = '0;
        r[4:0]   = m_en[ch];
        r[9:8]   = m_mode[ch];
        r[20:16] = m_sts[ch];
        return r;
    endfunction

    function automatic logic [31:0] exp_irq();
        logic [31:0] r = '0;
        for (int c = 0; c < NCH; c++) r[c] = |(m_sts[c] & m_en[c]);
        return r;
    endfunction

    function automatic logic [31:0] exp_raw();
        logic [31:0] r = '0;
        for (int c = 0; c < NCH; c++) r[c] = |m_sts[c];
        return r;
    endfunction

    function automatic logic [31:0] exp_done();
        logic [31:0] r = '0;
        for (int c = 0; c < NCH; c++) r[c] = m_done[c];
        return r;
    endfunction

    task automatic model_step(input logic we, input logic [7:0] addr,
                              input logic [31:0] wd, input logic [NCH*NS-1:0] e);
        for (int c = 0; c < NCH; c++) begin
            logic [4:0] clr = '0;
            logic       hit = 1'b0;
            for (int k = 0; k < 4; k++)
                if (e[c*NS + k] && (k >= int'(m_mode[c]))) hit = 1'b1;
            m_done[c] = hit;
            if (we && addr == ch_a(c)) begin
                m_en[c]   = wd[4:0];
                m_mode[c] = wd[9:8];
                clr       = wd[28:24];
            end
            m_sts[c] = (m_sts[c] & ~clr) | e[c*NS +: NS];
        end
    endtask

    task automatic sweep_reads();
        for (int c = 0; c < NCH; c++) begin
            reg_addr = ch_a(c);
            #0.4;
            check("R7 channel readback", reg_rdata, exp_reg(c));
        end
        reg_addr = 8'h10;
        #0.4;
        check("R6 raw word", reg_rdata, exp_raw());
        reg_addr = 8'h14;
        #0.4;
        check("R6 masked word", reg_rdata, exp_irq());
    endtask

    task automatic cyc(input logic we, input logic [7:0] addr,
                       input logic [31:0] wd, input logic [NCH*NS-1:0] e);
        reg_we    = we;
        reg_addr  = addr;
        reg_wdata = wd;
        evt_pulse = e;
        @(posedge clk);
        model_step(we, addr, wd, e);
        @(negedge clk);
        reg_we    = 1'b0;
        evt_pulse = '0;
        check("R3 irq lines", 32'(ch_irq), exp_irq());
        check("R6 raw port", 32'(glb_raw), exp_raw());
        check("R6 masked port", 32'(glb_masked), exp_irq());
        check("R8 done pulse", 32'(xfer_done), exp_done());
        sweep_reads();
    endtask

    task automatic rd_at(input logic [7:0] addr);
        reg_addr = addr;
        #0.4;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; evt_pulse = '0;
        for (int c = 0; c < NCH; c++) begin
            m_en[c] = '0; m_mode[c] = '0; m_sts[c] = '0; m_done[c] = 1'b0;
        end
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq after reset", 32'(ch_irq), 32'h0);
        check("R1 raw after reset", 32'(glb_raw), 32'h0);
        check("R1 done after reset", 32'(xfer_done), 32'h0);
        for (int c = 0; c < NCH; c++) begin
            rd_at(ch_a(c));
            check("R1 channel reg after reset", reg_rdata, 32'h0);
        end

        // R2 event latches while disabled
        cyc(1'b0, 8'h00, 32'h0, ev(0, 0));
        rd_at(ch_a(0));
        check("R2 status bit16 set with enable off", 32'(reg_rdata[20:16]), 32'h1);
        check("R2 irq stays low while disabled", 32'(ch_irq[0]), 32'h0);

        // R3 enabling raises the line
        cyc(1'b1, ch_a(0), 32'h0000_0001, '0);
        check("R3 irq after enable", 32'(ch_irq[0]), 32'h1);

        // R4 clear bit 24 empties status bit 16
        cyc(1'b1, ch_a(0), 32'h0100_0001, '0);
        rd_at(ch_a(0));
        check("R4 status cleared", 32'(reg_rdata[20:16]), 32'h0);
        check("R4 irq low after clear", 32'(ch_irq[0]), 32'h0);

        // R4 zero clear bits keep status
        cyc(1'b0, 8'h00, 32'h0, ev(0, 3));
        cyc(1'b1, ch_a(0), 32'h0700_0009, '0);
        rd_at(ch_a(0));
        check("R4 unselected bit kept", 32'(reg_rdata[20:16]), 32'h8);

        // R5 set wins over clear
        cyc(1'b1, ch_a(1), 32'h0200_0002, ev(1, 1));
        rd_at(ch_a(1));
        check("R5 set beats clear", 32'(reg_rdata[20:16]), 32'h2);
        check("R5 irq raised", 32'(ch_irq[1]), 32'h1);

        // R8 completion judged against mode
        cyc(1'b1, ch_a(2), 32'h0000_0200, '0);      // mode 2: transaction
        cyc(1'b0, 8'h00, 32'h0, ev(2, 1));
        check("R8 block below transaction mode", 32'(xfer_done[2]), 32'h0);
        cyc(1'b0, 8'h00, 32'h0, ev(2, 2));
        check("R8 transaction meets mode", 32'(xfer_done[2]), 32'h1);
        cyc(1'b0, 8'h00, 32'h0, '0);
        check("R8 pulse lasts one cycle", 32'(xfer_done[2]), 32'h0);
        cyc(1'b0, 8'h00, 32'h0, ev(2, 3));
        check("R8 list exceeds mode", 32'(xfer_done[2]), 32'h1);
        cyc(1'b0, 8'h00, 32'h0, ev(2, 4));
        check("R8 cfg error never completes", 32'(xfer_done[2]), 32'h0);
        cyc(1'b1, ch_a(2), 32'h0000_0000, '0);      // mode 0
        cyc(1'b1, ch_a(2), 32'h0000_0300, ev(2, 0)); // old mode 0 applies
        check("R8 old mode used on same-cycle write", 32'(xfer_done[2]), 32'h1);
        cyc(1'b0, 8'h00, 32'h0, ev(2, 2));
        check("R8 transaction below list mode", 32'(xfer_done[2]), 32'h0);

        // R9 writes elsewhere have no effect
        cyc(1'b1, 8'h10, 32'hFFFF_FFFF, '0);
        cyc(1'b1, 8'h14, 32'hFFFF_FFFF, '0);
        cyc(1'b1, 8'h3C, 32'hFFFF_FFFF, '0);
        cyc(1'b1, ch_a(NCH), 32'hFFFF_FFFF, '0);
        rd_at(8'h3C);
        check("R9 unmapped read is zero", reg_rdata, 32'h0);
        rd_at(ch_a(NCH));
        check("R9 past-last channel read is zero", reg_rdata, 32'h0);
        rd_at(ch_a(3));
        check("R9 channel 3 untouched", reg_rdata, exp_reg(3));

        // random traffic
        for (int n = 0; n < 1500; n++) begin
            logic [7:0]  a;
            logic [31:0] w;
            logic [NCH*NS-1:0] e;
            int sel = int'($urandom_range(0, 9));
            if (sel < 7)       a = ch_a(int'($urandom_range(0, NCH - 1)));
            else if (sel == 7) a = 8'h10;
            else if (sel == 8) a = 8'h14;
            else               a = 8'($urandom);
            w = $urandom;
            e = NCH*NS'($urandom & $urandom & $urandom);
            cyc(1'($urandom), a, w, e);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule